// File: doc/BRIEF.md
# CCD Row Black-Level Correction Coprocessor

This block is a fixed-function coprocessor that sits between an image sensor's parallel pixel output and a host processor. When the host issues a start command, the block captures a frame row by row. Each incoming row carries its active pixels together with reference samples. The block stores the row in a line buffer and derives a black-level bias from two reference columns of that row. It then writes the active pixels, minus the bias, into a frame store that the host reads back over its memory bus.

The block works through five phases: waiting for a command, capturing a row, computing the bias, correcting the row, and advancing to the next row. It accepts sensor pixels only while capturing. A subtraction that would fall below zero is clamped to zero. The host polls a status location to learn when the whole frame is ready.

Top module: `ccd_bias_corr`

## Requirements
- R1: After reset the block is idle: `pix_ready` is 0, the status location (address 0xFFF1) reads 0 and `hst_rdata` is 0.
- R2: A host write to address 0xFFF0 with data bit 0 set starts a frame while idle. From the cycle after that write until the frame is complete, the status location reads 1.
- R3: `pix_ready` is 1 only while a row is being captured. A pixel transfers on a clock edge where `pix_valid` and `pix_ready` are both 1. Each row takes exactly 66 transfers, for columns 0 to 65 in order, and `pix_ready` drops in the cycle after the 66th transfer.
- R4: The bias of a row is floor((column 10 + column 11) / 2), computed from that row's captured values. Each stored pixel for columns 0 to 63 equals the captured value minus that bias.
- R5: When a captured pixel is smaller than its row bias, the stored value is 0, not a wrapped value.
- R6: Corrected pixel (row r, column c) for c in 0..63 is read at address r*64+c (0x0000 to 0x0FFF). Columns 64 and 65 are not stored. Read data appears on `hst_rdata` in the cycle after the read strobe, and is 0 in any cycle that does not follow a read.
- R7: A start command that arrives while a frame is in progress is ignored. The running frame continues unchanged, and no new frame follows it.
- R8: After the 64th row has been corrected the block returns to idle. `pix_ready` then stays 0 even while `pix_valid` is held high, and the status location reads 0.
- R9: A write to the command address with data bit 0 clear does not start a frame. Reads of addresses outside the frame range and the status location return 0.
- R10: A start command issued after a completed frame captures a new frame, and its results replace every stored pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Sensor offers a pixel |
| pix_data | input | 8 | Sensor pixel value, 0 dark to 255 bright |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| hst_addr | input | 16 | Host address |
| hst_wdata | input | 8 | Host write data |
| hst_wr | input | 1 | Host write strobe, one cycle |
| hst_rd | input | 1 | Host read strobe, one cycle |
| hst_rdata | output | 8 | Host read data, valid the cycle after `hst_rd` |

## Verification
The bench sets both reference columns to 255 so that every pixel clamps. A design that wraps would return large values there. It also uses reference values with an odd sum, which catches a design that rounds the bias up instead of truncating. A start command injected part-way through a frame would, if obeyed, reset the row index and either corrupt the early rows or keep the status busy after the pixel stream ends. The bench checks that `pix_ready` falls right after the 66th pixel of a row, and that it stays low after the frame. A design that miscounts the row length, or that keeps accepting pixels, would shift every later row.

// File: rtl/ccdbc_pkg.sv
package ccdbc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_GET  = 3'd1,
      ST_BIAS = 3'd2,
      ST_FIX  = 3'd3,
      ST_NEXT = 3'd4
   } ccdbc_state_e;

   // Clamped subtraction: result never drops below zero
   function automatic logic [7:0] sub_clamp8(input logic [7:0] a, input logic [7:0] b);
      return (a > b) ? (a - b) : 8'd0;
   endfunction

endpackage

// File: rtl/ccdbc_seq.sv
module ccdbc_seq
   import ccdbc_pkg::*;
#(
   parameter int ROWS     = 64,
   parameter int LINE_LEN = 66,
   parameter int ACT_COLS = 64,
   localparam int ROW_W   = $clog2(ROWS),
   localparam int COL_W   = $clog2(LINE_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             pix_valid,
   output ccdbc_state_e     state_o,
   output logic [ROW_W-1:0] row_o,
   output logic [COL_W-1:0] col_o,
   output logic             accept_o,
   output logic             bias_ld_o,
   output logic             fix_we_o,
   output logic             pix_ready_o,
   output logic             busy_o
);

   ccdbc_state_e     state_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;

   assign pix_ready_o = (state_q == ST_GET);
   assign accept_o    = pix_ready_o && pix_valid;
   assign bias_ld_o   = (state_q == ST_BIAS);
   assign fix_we_o    = (state_q == ST_FIX);
   assign busy_o      = (state_q != ST_IDLE);
   assign state_o     = state_q;
   assign row_o       = row_q;
   assign col_o       = col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         col_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_GET;
               row_q   <= '0;
               col_q   <= '0;
            end
            ST_GET: if (pix_valid) begin
               col_q <= col_q + 1'b1;
               if (col_q == COL_W'(LINE_LEN - 1)) state_q <= ST_BIAS;
            end
            ST_BIAS: begin
               col_q   <= '0;
               state_q <= ST_FIX;
            end
            ST_FIX: begin
               if (col_q == COL_W'(ACT_COLS - 1)) state_q <= ST_NEXT;
               else col_q <= col_q + 1'b1;
            end
            ST_NEXT: begin
               col_q <= '0;
               if (row_q == ROW_W'(ROWS - 1)) begin
                  state_q <= ST_IDLE;
               end else begin
                  row_q   <= row_q + 1'b1;
                  state_q <= ST_GET;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ccdbc_line.sv
module ccdbc_line
   import ccdbc_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int LINE_LEN = 66,
   parameter int REF_A    = 10,
   parameter int REF_B    = 11,
   parameter bit SATURATE = 1'b1,
   localparam int COL_W   = $clog2(LINE_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [COL_W-1:0] wr_col,
   input  logic [PIX_W-1:0] wr_data,
   input  logic             bias_ld,
   input  logic [COL_W-1:0] rd_col,
   output logic [PIX_W-1:0] raw_o,
   output logic [PIX_W-1:0] corr_o
);

   logic [PIX_W-1:0] line_w [LINE_LEN];
   logic [PIX_W-1:0] bias_q;
   logic [PIX_W:0]   ref_sum;

   for (genvar i = 0; i < LINE_LEN; i++) begin : g_cell
      logic [PIX_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cell_q <= '0;
         else if (wr_en && (wr_col == COL_W'(i))) cell_q <= wr_data;
      end
      assign line_w[i] = cell_q;
   end

   assign ref_sum = {1'b0, line_w[REF_A]} + {1'b0, line_w[REF_B]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bias_q <= '0;
      else if (bias_ld) bias_q <= ref_sum[PIX_W:1];
   end

   assign raw_o = line_w[rd_col];

   if (SATURATE) begin : g_clamp
      if (PIX_W == 8) begin : g_w8
         assign corr_o = sub_clamp8(raw_o, bias_q);
      end else begin : g_wn
         assign corr_o = (raw_o > bias_q) ? (raw_o - bias_q) : '0;
      end
   end else begin : g_wrap
      assign corr_o = raw_o - bias_q;
   end

endmodule

// File: rtl/ccdbc_frame.sv
module ccdbc_frame #(
   parameter int PIX_W     = 8,
   parameter int ROWS      = 64,
   parameter int ACT_COLS  = 64,
   parameter int LINE_LEN  = 66,
   parameter int ADDR_W    = 16,
   parameter int STAT_ADDR = 16'hFFF1,
   localparam int DEPTH    = ROWS * ACT_COLS,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int ROW_W    = $clog2(ROWS),
   localparam int COL_W    = $clog2(LINE_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ROW_W-1:0]  wrow,
   input  logic [COL_W-1:0]  wcol,
   input  logic [PIX_W-1:0]  wdata,
   input  logic              busy,
   input  logic              hst_rd,
   input  logic [ADDR_W-1:0] hst_addr,
   output logic [PIX_W-1:0]  rdata
);

   logic [PIX_W-1:0] mem_q [DEPTH];
   logic [IDX_W-1:0] widx;

   assign widx = IDX_W'(wrow) * IDX_W'(ACT_COLS) + IDX_W'(wcol);

   always_ff @(posedge clk) begin
      if (we) mem_q[widx] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (!hst_rd) begin
         rdata <= '0;
      end else if (hst_addr < ADDR_W'(DEPTH)) begin
         rdata <= mem_q[hst_addr[IDX_W-1:0]];
      end else if (hst_addr == ADDR_W'(STAT_ADDR)) begin
         rdata <= PIX_W'(busy);
      end else begin
         rdata <= '0;
      end
   end

endmodule

// File: rtl/ccd_bias_corr.sv
module ccd_bias_corr
   import ccdbc_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int ROWS      = 64,
   parameter int ACT_COLS  = 64,
   parameter int REF_COLS  = 2,
   parameter int REF_A     = 10,
   parameter int REF_B     = 11,
   parameter bit SATURATE  = 1'b1,
   parameter int ADDR_W    = 16,
   parameter int CMD_ADDR  = 16'hFFF0,
   parameter int STAT_ADDR = 16'hFFF1,
   localparam int LINE_LEN = ACT_COLS + REF_COLS,
   localparam int ROW_W    = $clog2(ROWS),
   localparam int COL_W    = $clog2(LINE_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_data,
   output logic              pix_ready,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [PIX_W-1:0]  hst_wdata,
   input  logic              hst_wr,
   input  logic              hst_rd,
   output logic [PIX_W-1:0]  hst_rdata
);

   if (REF_A >= LINE_LEN || REF_B >= LINE_LEN) begin : g_bad_ref
      $error("reference column outside the captured row");
   end
   if (ROWS < 2 || ACT_COLS < 2) begin : g_bad_size
      $error("frame must have at least two rows and two columns");
   end
   if (ROWS * ACT_COLS > STAT_ADDR || CMD_ADDR == STAT_ADDR) begin : g_bad_map
      $error("host address map overlaps");
   end

   ccdbc_state_e     state;
   logic [ROW_W-1:0] row;
   logic [COL_W-1:0] col;
   logic             accept, bias_ld, fix_we, busy, start;
   logic [PIX_W-1:0] raw_pix, fix_data;

   assign start = hst_wr && (hst_addr == ADDR_W'(CMD_ADDR)) && hst_wdata[0];

   ccdbc_seq #(.ROWS(ROWS), .LINE_LEN(LINE_LEN), .ACT_COLS(ACT_COLS)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
      .state_o(state), .row_o(row), .col_o(col), .accept_o(accept),
      .bias_ld_o(bias_ld), .fix_we_o(fix_we), .pix_ready_o(pix_ready), .busy_o(busy)
   );

   ccdbc_line #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN), .REF_A(REF_A), .REF_B(REF_B),
                .SATURATE(SATURATE)) line_i (
      .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_col(col), .wr_data(pix_data),
      .bias_ld(bias_ld), .rd_col(col), .raw_o(raw_pix), .corr_o(fix_data)
   );

   ccdbc_frame #(.PIX_W(PIX_W), .ROWS(ROWS), .ACT_COLS(ACT_COLS), .LINE_LEN(LINE_LEN),
                 .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) frame_i (
      .clk(clk), .rst_n(rst_n), .we(fix_we), .wrow(row), .wcol(col), .wdata(fix_data),
      .busy(busy), .hst_rd(hst_rd), .hst_addr(hst_addr), .rdata(hst_rdata)
   );

endmodule

// File: rtl/ccd_bias_corr_chk.sv
module ccd_bias_corr_chk
   import ccdbc_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int ROWS     = 64,
   parameter int LINE_LEN = 66,
   localparam int ROW_W   = $clog2(ROWS),
   localparam int COL_W   = $clog2(LINE_LEN)
) (
   input logic             clk,
   input logic             rst_n,
   input ccdbc_state_e     state,
   input logic [ROW_W-1:0] row,
   input logic [COL_W-1:0] col,
   input logic             accept,
   input logic             start,
   input logic             busy,
   input logic             pix_ready,
   input logic             fix_we,
   input logic [PIX_W-1:0] fix_data,
   input logic [PIX_W-1:0] raw_pix,
   input logic             hst_rd,
   input logic [PIX_W-1:0] hst_rdata
);

   // R2: a start while idle opens row capture on the next cycle
   a_r2_start_opens_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && pix_ready));

   // R3: the last column of a row closes the pixel port
   a_r3_row_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && col == COL_W'(LINE_LEN - 1)) |=> !pix_ready);

   // R5: a stored value never exceeds the captured pixel it came from
   a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      fix_we |-> (fix_data <= raw_pix));

   // R6: read data is zero unless a read strobe preceded it
   a_r6_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hst_rd) |-> (hst_rdata == '0));

   // R7: a start during a frame leaves the row index alone
   a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && state != ST_NEXT) |=> $stable(row));

   // R8: after the last row the block is idle
   a_r8_frame_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NEXT && row == ROW_W'(ROWS - 1)) |=> (!busy && !pix_ready));

endmodule

bind ccd_bias_corr ccd_bias_corr_chk #(.PIX_W(PIX_W), .ROWS(ROWS), .LINE_LEN(LINE_LEN)) chk_i (
   .clk(clk), .rst_n(rst_n), .state(state), .row(row), .col(col), .accept(accept),
   .start(start), .busy(busy), .pix_ready(pix_ready), .fix_we(fix_we),
   .fix_data(fix_data), .raw_pix(raw_pix), .hst_rd(hst_rd), .hst_rdata(hst_rdata)
);

// File: tb/ccd_bias_corr_tb_top.sv
module ccd_bias_corr_tb_top;

   localparam int ROWS = 64;
   localparam int ACT  = 64;
   localparam int LINE = 66;
   localparam logic [15:0] CMD  = 16'hFFF0;
   localparam logic [15:0] STAT = 16'hFFF1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid = 1'b0;
   logic [7:0]  pix_data = '0;
   logic        pix_ready;
   logic [15:0] hst_addr = '0;
   logic [7:0]  hst_wdata = '0;
   logic        hst_wr = 1'b0;
   logic        hst_rd = 1'b0;
   logic [7:0]  hst_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ccd_bias_corr dut_i (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
      .pix_ready(pix_ready), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
      .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_rdata(hst_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // mode 0: mixed pattern; 2: bright references; 3: references 200/201
   function automatic logic [7:0] pix_of(int mode, int r, int c);
      logic [7:0] v;
      v = 8'((r * 7 + c * 13 + (r ^ c) * 3 + mode * 29) & 255);
      if (c == 10 || c == 11) begin
         case (mode)
            2: v = 8'd255;
            3: v = (c == 10) ? 8'd200 : 8'd201;
            default: v = 8'((r * 5 + c) & 127);
         endcase
      end
      if (c >= ACT) v = 8'd250;
      return v;
   endfunction

   function automatic logic [7:0] exp_of(int mode, int r, int c);
      int b, p;
      b = (int'(pix_of(mode, r, 10)) + int'(pix_of(mode, r, 11))) / 2;
      p = int'(pix_of(mode, r, c));
      return (p > b) ? 8'(p - b) : 8'd0;
   endfunction

   task automatic hw(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
      @(negedge clk);
      hst_wr = 1'b0;
   endtask

   task automatic hr(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      hst_addr = a; hst_rd = 1'b1;
      @(negedge clk);
      hst_rd = 1'b0;
      d = hst_rdata;
   endtask

   task automatic feed(input int mode);
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < LINE; c++) begin
            @(negedge clk);
            pix_valid = 1'b1; pix_data = pix_of(mode, r, c);
            while (!pix_ready) @(negedge clk);
            @(posedge clk);
            if (r == 0 && c == LINE - 1) begin
               @(negedge clk);
               pix_valid = 1'b0;
               chk(pix_ready == 1'b0, "R3 ready low after 66th pixel", pix_ready, 0);
            end
         end
      end
      @(negedge clk);
      pix_valid = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      s = 8'd1;
      for (int k = 0; k < 2000 && s != 0; k++) hr(STAT, s);
      chk(s == 8'd0, "R8 status returns to 0", s, 0);
   endtask

   task automatic check_frame(input int mode);
      logic [7:0] d, e;
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < ACT; c++) begin
            hr(16'(r * ACT + c), d);
            e = exp_of(mode, r, c);
            if (e == 0 && pix_of(mode, r, c) != 0)
               chk(d == e, $sformatf("R5 clamp r%0d c%0d", r, c), d, e);
            else
               chk(d == e, $sformatf("R4 corrected r%0d c%0d", r, c), d, e);
         end
      end
   endtask

   task automatic t_reset();
      logic [7:0] s;
      chk(pix_ready == 1'b0, "R1 ready after reset", pix_ready, 0);
      chk(hst_rdata == 8'd0, "R1 rdata after reset", hst_rdata, 0);
      hr(STAT, s);
      chk(s == 8'd0, "R1 status after reset", s, 0);
   endtask

   task automatic t_no_start();
      logic [7:0] s;
      hw(CMD, 8'h02);
      hr(STAT, s);
      chk(s == 8'd0, "R9 cmd with bit0 clear", s, 0);
      chk(pix_ready == 1'b0, "R9 ready stays low", pix_ready, 0);
      hr(16'h1000, s);
      chk(s == 8'd0, "R9 unmapped read 0x1000", s, 0);
      hr(16'hFFF0, s);
      chk(s == 8'd0, "R9 command address reads 0", s, 0);
   endtask

   task automatic t_frame_busy_cmd();
      logic [7:0] s;
      hw(CMD, 8'h01);
      hr(STAT, s);
      chk(s == 8'd1, "R2 status busy after start", s, 1);
      fork
         feed(0);
         begin
            repeat (1500) @(negedge clk);
            hw(CMD, 8'h01);
         end
      join
      wait_idle();
      repeat (20) @(negedge clk);
      hr(STAT, s);
      chk(s == 8'd0, "R7 no restart after busy command", s, 0);
      check_frame(0);
      hr(16'(1 * ACT + 0), s);
      chk(s == exp_of(0, 1, 0), "R6 address r*64+c", s, exp_of(0, 1, 0));
   endtask

   task automatic t_idle_ready();
      @(negedge clk);
      pix_valid = 1'b1; pix_data = 8'd77;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(pix_ready == 1'b0, "R8 ready low with valid after frame", pix_ready, 0);
      end
      pix_valid = 1'b0;
   endtask

   task automatic t_frame(input int mode, input string tag);
      logic [7:0] s;
      hw(CMD, 8'h01);
      hr(STAT, s);
      chk(s == 8'd1, tag, s, 1);
      feed(mode);
      wait_idle();
      check_frame(mode);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_start();
      t_frame_busy_cmd();
      t_idle_ready();
      t_frame(2, "R10 new frame starts (bright refs)");
      t_frame(3, "R10 new frame starts (odd ref sum)");
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule